// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Byte-Lane Masks

A single-clock static memory array whose accesses are pipelined: every control input and the address are taken at a rising clock edge. A read returns the whole word during the following clock cycle. A write is late. Its address and byte-lane mask are captured at one edge, and its data is captured at the next edge. The word is 36 bits wide and is split into four 9-bit lanes. Each lane has its own active-low write enable, and every one of the sixteen mask patterns is allowed.

The block decodes one operation per edge. In priority order these are: sleep, deselect, write, dummy read (array accessed, bus left idle) and read. A sleep request overrides all other inputs. A write that is waiting for its data lives in a pending register. It is committed at the edge that brings its data. If a read of the same address arrives at that edge, the enabled lanes are forwarded from the incoming data, so the read always returns the newest value.

The controller has two named states. PH_IDLE means no write is pending. PH_WDATA means a write is waiting for its data. A write operation moves either state to PH_WDATA. Any other operation moves either state to PH_IDLE. Reset also returns to PH_IDLE. Leaving PH_WDATA commits the pending write to the array, except when the edge carries a sleep request or a reset. The data bus is modelled as an input `d_in`, an output `q_out` and a drive qualifier `q_oe`. When `q_oe` is low, the bus is high-impedance.

Top module: `lw_sram`

## Requirements
- R1: While `sleep_req` is high, `q_oe` is low in that cycle and in the cycle after the edge. No operation is decoded, and the array is not written.
- R2: With `sleep_req` low and `sel_n` high, the edge is a dead cycle. `q_oe` is low in the next cycle, and the array is unchanged whatever the write enables are.
- R3: With `sel_n` low, `we_n` high and `oe_n` high, the edge is a dummy read. `q_oe` stays low in the next cycle.
- R4: With `sel_n` low, `we_n` high and `oe_n` low, the edge is a read. In the next cycle `q_oe` is high and `q_out` holds all 36 bits of the addressed word.
- R5: With `sel_n` low and `we_n` low, the edge is a write. Lane k occupies bits 9k+8 down to 9k. Lane k is written from `d_in` sampled at the next edge exactly when `bwe_n[k]` was low at the address edge. Lanes whose enable was high keep their contents, for all 16 mask values.
- R6: In the cycle after a write's address edge, `q_oe` is low.
- R7: A read whose address equals a pending write's address, at that write's data edge, returns the enabled lanes from `d_in` and the remaining lanes from the array.
- R8: A write may be issued at the data edge of the previous write. Both writes take effect with their own addresses, masks and data.
- R9: A synchronous reset (`rst` high at an edge) clears the pending write and the output drive, so `q_oe` is low after it. Array contents are kept.
- R10: A sleep request at a pending write's data edge discards that write, and the array keeps its old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sleep_req | input | 1 | Sleep request, overrides every other input |
| sel_n | input | 1 | Select, active low |
| oe_n | input | 1 | Output enable for reads, active low |
| we_n | input | 1 | Global write enable, active low |
| bwe_n | input | LANES | Per-lane write enables, active low |
| addr | input | AW | Word address |
| d_in | input | LANES*LANE_W | Write data, taken one edge after the write address |
| q_out | output | LANES*LANE_W | Read data |
| q_oe | output | 1 | High when `q_out` drives the bus; low means high-impedance |

## Verification
The bench targets these cases:
- A read of an address whose write is still waiting for data. A design without forwarding would return the stale word.
- Back-to-back writes where the second address arrives together with the first write's data. A design that reuses one pending register carelessly would commit data to the wrong address or with the wrong mask.
- All sixteen lane masks. A wrong lane map would corrupt neighbouring bits.
- A sleep request or a reset landing on a data edge. A design that honours them late would still write the array.
- Deselect and dummy-read cycles with the write enables low. A design with the wrong decode priority would write the array or drive the bus.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    // Operation decoded from the controls at one clock edge
    typedef enum logic [2:0] {
        OP_SLEEP,
        OP_DESEL,
        OP_DUMMY,
        OP_READ,
        OP_WRITE
    } op_e;

    // Controller state: whether a late write waits for its data
    typedef enum logic {
        PH_IDLE,
        PH_WDATA
    } phase_e;

endpackage

// File: rtl/lw_sram_decode.sv
module lw_sram_decode
    import lw_sram_pkg::*;
(
    input  logic sleep_req,
    input  logic sel_n,
    input  logic oe_n,
    input  logic we_n,
    output op_e  op
);

    // Priority: sleep, deselect, write, dummy read, read
    always_comb begin
        if (sleep_req)  op = OP_SLEEP;
        else if (sel_n) op = OP_DESEL;
        else if (!we_n) op = OP_WRITE;
        else if (oe_n)  op = OP_DUMMY;
        else            op = OP_READ;
    end

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
    parameter int DEPTH  = 64,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int WW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [LANES-1:0] wr_mask,
    input  logic [WW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WW-1:0]    rd_data
);

    // One independent bank per lane so each lane has its own write port
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[g]) begin
                bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = bank[rd_addr];
    end

endmodule

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
    import lw_sram_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int WW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  op_e              op,
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] bwe_n,
    input  logic [WW-1:0]    d_in,
    input  logic [WW-1:0]    arr_rdata,
    output logic             arr_we,
    output logic [AW-1:0]    arr_waddr,
    output logic [LANES-1:0] arr_wmask,
    output logic             drv_q,
    output logic [WW-1:0]    rd_q
);

    phase_e           phase_q, phase_d;
    logic [AW-1:0]    pend_addr_q;
    logic [LANES-1:0] pend_mask_q;
    logic             commit;
    logic             hit;
    logic [WW-1:0]    fwd_word;

    // Next-state logic
    always_comb begin
        unique case (phase_q)
            PH_IDLE:  phase_d = (op == OP_WRITE) ? PH_WDATA : PH_IDLE;
            PH_WDATA: phase_d = (op == OP_WRITE) ? PH_WDATA : PH_IDLE;
            default:  phase_d = PH_IDLE;
        endcase
    end

    // State register and the reset-cleared output drive
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            drv_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            drv_q   <= (op == OP_READ);
        end
    end

    // Datapath registers without reset
    always_ff @(posedge clk) begin
        if (!rst && op == OP_WRITE) begin
            pend_addr_q <= addr;
            pend_mask_q <= ~bwe_n;
        end
        if (!rst && op == OP_READ) begin
            rd_q <= fwd_word;
        end
    end

    // Per-state outputs: leaving PH_WDATA commits unless sleep or reset
    always_comb begin
        unique case (phase_q)
            PH_IDLE:  commit = 1'b0;
            PH_WDATA: commit = (op != OP_SLEEP) && !rst;
            default:  commit = 1'b0;
        endcase
    end

    assign arr_we    = commit;
    assign arr_waddr = pend_addr_q;
    assign arr_wmask = pend_mask_q;

    // Forwarding of enabled lanes from data arriving at this edge
    assign hit = (phase_q == PH_WDATA) && (pend_addr_q == addr);

    for (genvar g = 0; g < LANES; g++) begin : g_fwd
        assign fwd_word[g*LANE_W +: LANE_W] = (hit && pend_mask_q[g])
                                            ? d_in[g*LANE_W +: LANE_W]
                                            : arr_rdata[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int WW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_req,
    input  logic             sel_n,
    input  logic             oe_n,
    input  logic             we_n,
    input  logic [LANES-1:0] bwe_n,
    input  logic [AW-1:0]    addr,
    input  logic [WW-1:0]    d_in,
    output logic [WW-1:0]    q_out,
    output logic             q_oe
);

    op_e              op;
    logic             arr_we;
    logic [AW-1:0]    arr_waddr;
    logic [LANES-1:0] arr_wmask;
    logic [WW-1:0]    arr_rdata;
    logic             drv_q;
    logic [WW-1:0]    rd_q;

    lw_sram_decode u_dec (
        .sleep_req (sleep_req),
        .sel_n     (sel_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .op        (op)
    );

    lw_sram_ctrl #(
        .AW     (AW),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .addr      (addr),
        .bwe_n     (bwe_n),
        .d_in      (d_in),
        .arr_rdata (arr_rdata),
        .arr_we    (arr_we),
        .arr_waddr (arr_waddr),
        .arr_wmask (arr_wmask),
        .drv_q     (drv_q),
        .rd_q      (rd_q)
    );

    lw_sram_array #(
        .DEPTH  (DEPTH),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_arr (
        .clk     (clk),
        .wr_en   (arr_we),
        .wr_addr (arr_waddr),
        .wr_mask (arr_wmask),
        .wr_data (d_in),
        .rd_addr (addr),
        .rd_data (arr_rdata)
    );

    // Sleep forces high-impedance in the current cycle as well
    assign q_oe  = drv_q && !sleep_req;
    assign q_out = rd_q;

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk (
    input logic clk,
    input logic rst,
    input logic sleep_req,
    input logic sel_n,
    input logic oe_n,
    input logic we_n,
    input logic arr_we,
    input logic q_oe
);

    // R1
    sleep_now_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_req |-> !q_oe);

    // R1
    sleep_next_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_req |=> !q_oe);

    // R10
    sleep_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_req |-> !arr_we);

    // R2
    desel_chk: assert property (@(posedge clk) disable iff (rst)
        (!sleep_req && sel_n) |=> !q_oe);

    // R3
    dummy_chk: assert property (@(posedge clk) disable iff (rst)
        (!sleep_req && !sel_n && we_n && oe_n) |=> !q_oe);

    // R4
    read_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (!sleep_req && !sel_n && we_n && !oe_n) |=> (q_oe || sleep_req));

    // R6
    write_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        (!sleep_req && !sel_n && !we_n) |=> !q_oe);

endmodule

bind lw_sram lw_sram_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sleep_req (sleep_req),
    .sel_n     (sel_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .arr_we    (arr_we),
    .q_oe      (q_oe)
);

// File: tb/tb_lw_sram.sv
`timescale 1ns/1ps
module tb_lw_sram;
    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int W     = 36;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sleep_req = 1'b0;
    logic          sel_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic [3:0]    bwe_n = 4'hf;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  d_in = '0;
    logic [W-1:0]  q_out;
    logic          q_oe;

    always #10 clk = ~clk;

    lw_sram #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .sel_n(sel_n),
        .oe_n(oe_n), .we_n(we_n), .bwe_n(bwe_n), .addr(addr),
        .d_in(d_in), .q_out(q_out), .q_oe(q_oe)
    );

    // Reference model
    logic [W-1:0]  ref_mem [DEPTH];
    bit            m_pend = 0;
    bit            m_drv = 0;
    logic [AW-1:0] m_pa = '0;
    logic [3:0]    m_pm = '0;
    logic [W-1:0]  m_q = '0;
    string         m_tag = "R9";
    string         tag_over = "";
    int            checks = 0;
    int            fails = 0;

    function automatic logic [W-1:0] merge(logic [W-1:0] old, logic [W-1:0] nw, logic [3:0] en);
        logic [W-1:0] r = old;
        for (int k = 0; k < 4; k++) if (en[k]) r[k*9 +: 9] = nw[k*9 +: 9];
        return r;
    endfunction

    function automatic logic [W-1:0] rnd36();
        return {$urandom[3:0], $urandom};
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(bit rs, bit slp, bit sn, bit on, bit wn, logic [3:0] bw,
                        int a, logic [W-1:0] d);
        logic [W-1:0] word;
        bit           fwd;
        @(negedge clk);
        rst = rs; sleep_req = slp; sel_n = sn; oe_n = on; we_n = wn;
        bwe_n = bw; addr = a[AW-1:0]; d_in = d;
        #1;
        chk((m_drv && slp) ? "R1" : m_tag, {35'd0, q_oe}, {35'd0, m_drv && !slp});
        if (m_drv && !slp) chk(m_tag, q_out, m_q);
        if (rs) begin
            m_pend = 0; m_drv = 0; m_tag = "R9";
        end else if (slp) begin
            m_pend = 0; m_drv = 0; m_tag = "R1";
        end else begin
            word = ref_mem[a];
            fwd  = m_pend && (m_pa == a[AW-1:0]);
            if (fwd) word = merge(word, d, m_pm);
            if (m_pend) ref_mem[m_pa] = merge(ref_mem[m_pa], d, m_pm);
            m_pend = 0; m_drv = 0;
            if (sn) m_tag = "R2";
            else if (!wn) begin
                m_pend = 1; m_pa = a[AW-1:0]; m_pm = ~bw; m_tag = "R6";
            end else if (on) m_tag = "R3";
            else begin
                m_drv = 1; m_q = word;
                m_tag = (tag_over != "") ? tag_over : (fwd ? "R7" : "R4");
            end
        end
    endtask

    task automatic idle();
        step(0, 0, 1, 1, 1, 4'hf, 0, rnd36());
    endtask
    task automatic rd(int a);
        step(0, 0, 0, 0, 1, 4'hf, a, rnd36());
    endtask
    task automatic wr(int a, logic [3:0] bw, logic [W-1:0] d);
        step(0, 0, 0, 1, 0, bw, a, rnd36());
        step(0, 0, 1, 1, 1, 4'hf, 0, d);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        // R9: reset state
        step(1, 0, 1, 1, 1, 4'hf, 0, '0);
        step(1, 0, 1, 1, 1, 4'hf, 0, '0);
        for (int a = 0; a < DEPTH; a++) wr(a, 4'h0, rnd36());
        for (int a = 0; a < DEPTH; a++) rd(a);
        idle();

        // R5: all 16 lane masks
        for (int m = 0; m < 16; m++) begin
            wr(3, m[3:0], rnd36());
            tag_over = "R5"; rd(3); tag_over = "";
        end
        idle();

        // R7: read during the data edge of a pending write
        step(0, 0, 0, 1, 0, 4'b1010, 5, rnd36());
        rd(5);
        step(0, 0, 0, 1, 0, 4'b0000, 5, rnd36());
        step(0, 0, 0, 0, 1, 4'hf, 5, rnd36());
        idle();

        // R8: back-to-back writes
        step(0, 0, 0, 1, 0, 4'b0000, 6, rnd36());
        step(0, 0, 0, 1, 0, 4'b0011, 7, rnd36());
        step(0, 0, 0, 1, 0, 4'b1100, 6, rnd36());
        idle();
        tag_over = "R8"; rd(6); rd(7); tag_over = "";

        // R10: sleep on the data edge discards the write
        step(0, 0, 0, 1, 0, 4'h0, 8, rnd36());
        step(0, 1, 0, 0, 1, 4'h0, 8, rnd36());
        step(0, 1, 1, 1, 1, 4'hf, 0, rnd36());
        tag_over = "R10"; rd(8); tag_over = "";
        // R1: sleep right after a read hides the output
        rd(2);
        step(0, 1, 0, 0, 0, 4'h0, 2, rnd36());
        idle();

        // R9: reset on a data edge drops the write, array kept
        step(0, 0, 0, 1, 0, 4'h0, 9, rnd36());
        step(1, 0, 0, 1, 1, 4'hf, 0, rnd36());
        tag_over = "R9"; rd(9); rd(1); tag_over = "";

        // R2: deselect with write enables low writes nothing
        step(0, 0, 1, 0, 0, 4'h0, 10, rnd36());
        step(0, 0, 1, 1, 1, 4'hf, 0, rnd36());
        tag_over = "R2"; rd(10); tag_over = "";
        // R3: dummy read
        step(0, 0, 0, 1, 1, 4'h0, 11, rnd36());
        idle();

        // Constrained random traffic
        for (int i = 0; i < 600; i++) begin
            int unsigned r = $urandom % 100;
            int          a = int'($urandom % DEPTH);
            if (r < 4)       step(0, 1, $urandom%2, $urandom%2, $urandom%2, 4'($urandom), a, rnd36());
            else if (r < 12) step(0, 0, 1, $urandom%2, $urandom%2, 4'($urandom), a, rnd36());
            else if (r < 20) step(0, 0, 0, 1, 1, 4'($urandom), a, rnd36());
            else if (r < 55) step(0, 0, 0, 1, 0, 4'($urandom), a, rnd36());
            else             step(0, 0, 0, 0, 1, 4'($urandom), a, rnd36());
        end
        idle();
        for (int a = 0; a < DEPTH; a++) rd(a);
        idle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule